// File: doc/BRIEF.md
# GPIO Bank with Interrupt Detection

A bank of up to 32 general-purpose lines behind a 32-bit register interface. Each line works as a plain input, a plain output, or an interrupt input. Interrupt inputs detect either a level or an edge. A per-line polarity bit inverts the sampled pin before qualification. A per-line both-edge bit makes any transition count, whatever the polarity.

Every line has a status bit and an enable (mask) bit. Edge status is latched until software clears it by writing 1. Enables are set through one register and removed through another. The bank raises a single interrupt request while any line has both its status and its enable set.

The bus side has a request channel (valid, write flag, byte address, write data) that is always ready. A read returns its data one cycle after it is accepted. Pins pass through a two-flop synchronizer before any use.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset every register reads 0, `pad_oe_o` is all 0 and `irq_o` is 0.
- R2: `pad_oe_o[i]` is 1 exactly when the mode bit (offset 0x00) of line i is 0 (general I/O) and its direction bit (offset 0x04) is 1 (output). `pad_out_o` always equals the output data register (offset 0x08), and reading 0x08 returns the value last written there.
- R3: Reading offset 0x0C returns the synchronized pin levels, with no polarity inversion applied.
- R4: A line with mode bit 1 and edge/level bit (offset 0x24) 0 is level-sensitive. Its status bit equals the synchronized pin XOR its polarity bit (offset 0x20) on every cycle, and a clear write has no lasting effect on it.
- R5: A line with mode bit 1, edge/level bit 1 and both-edge bit (offset 0x4C) 0 latches status on a rising pin edge when polarity is 0, or on a falling edge when polarity is 1. The status stays set until it is cleared.
- R6: With the both-edge bit at 1, an edge-mode line latches status on either transition, regardless of polarity.
- R7: Writing offset 0x14 clears the latched edge status of every line whose written bit is 1. Lines whose written bit is 0 keep their status.
- R8: Writing offset 0x1C sets the enable of every line written as 1. Writing offset 0x18 clears the enable of every line written as 0 and leaves lines written as 1 unchanged. Offset 0x18 reads back the enables.
- R9: Offset 0x10 returns the status whatever the enables are. `irq_o` is 1 exactly when some line has both status and enable set.
- R10: A line with mode bit 0 never sets its status, whatever its pin does.
- R11: `req_ready_o` is 1 outside reset. A read raises `rsp_valid_o` with its data on the cycle after acceptance. Writes to 0x10 are ignored. Reads of 0x14, 0x1C and unmapped offsets return 0.
- R12: A pin change driven before clock edge k appears in a read of 0x0C accepted at edge k+2 but not at edge k+1. The status and `irq_o` change it causes are visible after edge k+2 and not after edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Bus request valid |
| req_ready_o | output | 1 | Bus request ready |
| req_write_i | input | 1 | 1 for write, 0 for read |
| req_addr_i | input | 7 | Byte address of the register |
| req_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Read data valid |
| rsp_rdata_o | output | 32 | Read data |
| pad_in_i | input | NUM_LINES | Pin levels from the pads |
| pad_out_o | output | NUM_LINES | Output levels to the pads |
| pad_oe_o | output | NUM_LINES | Per-pad output enable |
| irq_o | output | 1 | Combined interrupt request |

## Verification
Register writes take effect at the edge that accepts them, and read data appears one edge later. A pin change needs two edges to reach the input data register and a third edge to reach status and `irq_o`. The bench drives every input on the falling clock edge. After a pin change it waits three falling edges before it reads status, or samples on purpose one edge early to show the old value. Each read is checked on the falling edge that follows the rising edge that returned it.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int unsigned REG_ADDR_W = 7;
  localparam int unsigned REG_DATA_W = 32;
  localparam int unsigned MAX_LINES  = 32;

  localparam logic [REG_ADDR_W-1:0] OFF_MODE   = 7'h00;
  localparam logic [REG_ADDR_W-1:0] OFF_DIR    = 7'h04;
  localparam logic [REG_ADDR_W-1:0] OFF_DOUT   = 7'h08;
  localparam logic [REG_ADDR_W-1:0] OFF_DIN    = 7'h0C;
  localparam logic [REG_ADDR_W-1:0] OFF_STAT   = 7'h10;
  localparam logic [REG_ADDR_W-1:0] OFF_CLR    = 7'h14;
  localparam logic [REG_ADDR_W-1:0] OFF_MASK   = 7'h18;
  localparam logic [REG_ADDR_W-1:0] OFF_UNMASK = 7'h1C;
  localparam logic [REG_ADDR_W-1:0] OFF_POL    = 7'h20;
  localparam logic [REG_ADDR_W-1:0] OFF_EDGE   = 7'h24;
  localparam logic [REG_ADDR_W-1:0] OFF_BOTH   = 7'h4C;

  typedef struct packed {
    logic [MAX_LINES-1:0] mode;
    logic [MAX_LINES-1:0] pol;
    logic [MAX_LINES-1:0] edge_sel;
    logic [MAX_LINES-1:0] both;
  } det_cfg_t;
endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] pin_i,
  output logic [WIDTH-1:0] cur_o,
  output logic [WIDTH-1:0] prev_o
);
  logic [WIDTH-1:0] meta_q, cur_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      cur_q  <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= pin_i;
      cur_q  <= meta_q;
      prev_q <= cur_q;
    end
  end

  assign cur_o  = cur_q;
  assign prev_o = prev_q;
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NUM_LINES = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] cur_i,
  input  logic [NUM_LINES-1:0] prev_i,
  input  det_cfg_t             cfg_i,
  input  logic [NUM_LINES-1:0] clr_i,
  output logic [NUM_LINES-1:0] status_o
);
  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    logic qual, qual_prev, hit, st_q;

    assign qual      = cur_i[i] ^ cfg_i.pol[i];
    assign qual_prev = prev_i[i] ^ cfg_i.pol[i];
    assign hit       = cfg_i.both[i] ? (cur_i[i] != prev_i[i]) : (qual & ~qual_prev);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                 st_q <= 1'b0;
      else if (!cfg_i.mode[i])     st_q <= 1'b0;
      else if (!cfg_i.edge_sel[i]) st_q <= qual;
      else if (hit)                st_q <= 1'b1;   // new event wins over clear
      else if (clr_i[i])           st_q <= 1'b0;
    end

    assign status_o[i] = st_q;

    AST_IO_MODE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !cfg_i.mode[i] |=> !st_q); // R10
    AST_LEVEL_IGNORES_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cfg_i.mode[i] && !cfg_i.edge_sel[i] && clr_i[i]) |=> st_q == ($past(cur_i[i]) ^ $past(cfg_i.pol[i]))); // R4
    AST_EDGE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cfg_i.mode[i] && cfg_i.edge_sel[i] && st_q && !clr_i[i]) |=> st_q); // R5
    AST_EDGE_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cfg_i.mode[i] && cfg_i.edge_sel[i] && clr_i[i] && cur_i[i] == prev_i[i]) |=> !st_q); // R7
  end
endmodule

// File: rtl/gpio_reg_file.sv
module gpio_reg_file
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NUM_LINES = 32
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_valid_i,
  input  logic                  req_write_i,
  input  logic [REG_ADDR_W-1:0] req_addr_i,
  input  logic [REG_DATA_W-1:0] req_wdata_i,
  output logic                  rsp_valid_o,
  output logic [REG_DATA_W-1:0] rsp_rdata_o,
  input  logic [NUM_LINES-1:0]  din_i,
  input  logic [NUM_LINES-1:0]  status_i,
  output logic [NUM_LINES-1:0]  mode_o,
  output logic [NUM_LINES-1:0]  dir_o,
  output logic [NUM_LINES-1:0]  dout_o,
  output logic [NUM_LINES-1:0]  pol_o,
  output logic [NUM_LINES-1:0]  edge_o,
  output logic [NUM_LINES-1:0]  both_o,
  output logic [NUM_LINES-1:0]  mask_o,
  output logic [NUM_LINES-1:0]  clr_o
);
  logic [NUM_LINES-1:0] mode_q, dir_q, dout_q, pol_q, edge_q, both_q, mask_q;
  logic [NUM_LINES-1:0] wd;
  logic                 wr_en, rd_en, rsp_valid_q;
  logic [REG_DATA_W-1:0] rd_mux, rdata_q;

  assign wd    = req_wdata_i[NUM_LINES-1:0];
  assign wr_en = req_valid_i &  req_write_i;
  assign rd_en = req_valid_i & ~req_write_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0; dir_q <= '0; dout_q <= '0; pol_q <= '0;
      edge_q <= '0; both_q <= '0; mask_q <= '0;
    end else if (wr_en) begin
      unique case (req_addr_i)
        OFF_MODE:   mode_q <= wd;
        OFF_DIR:    dir_q  <= wd;
        OFF_DOUT:   dout_q <= wd;
        OFF_POL:    pol_q  <= wd;
        OFF_EDGE:   edge_q <= wd;
        OFF_BOTH:   both_q <= wd;
        OFF_MASK:   mask_q <= mask_q & wd;
        OFF_UNMASK: mask_q <= mask_q | wd;
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (req_addr_i)
      OFF_MODE: rd_mux = REG_DATA_W'(mode_q);
      OFF_DIR:  rd_mux = REG_DATA_W'(dir_q);
      OFF_DOUT: rd_mux = REG_DATA_W'(dout_q);
      OFF_DIN:  rd_mux = REG_DATA_W'(din_i);
      OFF_STAT: rd_mux = REG_DATA_W'(status_i);
      OFF_MASK: rd_mux = REG_DATA_W'(mask_q);
      OFF_POL:  rd_mux = REG_DATA_W'(pol_q);
      OFF_EDGE: rd_mux = REG_DATA_W'(edge_q);
      OFF_BOTH: rd_mux = REG_DATA_W'(both_q);
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_q <= 1'b0;
      rdata_q     <= '0;
    end else begin
      rsp_valid_q <= rd_en;
      if (rd_en) rdata_q <= rd_mux;
    end
  end

  assign clr_o       = (wr_en && req_addr_i == OFF_CLR) ? wd : '0;
  assign rsp_valid_o = rsp_valid_q;
  assign rsp_rdata_o = rdata_q;
  assign mode_o = mode_q;
  assign dir_o  = dir_q;
  assign dout_o = dout_q;
  assign pol_o  = pol_q;
  assign edge_o = edge_q;
  assign both_o = both_q;
  assign mask_o = mask_q;

  AST_MASK_KEEP_ONES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en && req_addr_i == OFF_MASK && &wd) |=> $stable(mask_q)); // R8
  AST_RSP_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en |=> rsp_valid_o); // R11
  AST_RSP_ONLY_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en |=> !rsp_valid_o); // R11
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NUM_LINES = 32
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_valid_i,
  output logic                  req_ready_o,
  input  logic                  req_write_i,
  input  logic [REG_ADDR_W-1:0] req_addr_i,
  input  logic [REG_DATA_W-1:0] req_wdata_i,
  output logic                  rsp_valid_o,
  output logic [REG_DATA_W-1:0] rsp_rdata_o,
  input  logic [NUM_LINES-1:0]  pad_in_i,
  output logic [NUM_LINES-1:0]  pad_out_o,
  output logic [NUM_LINES-1:0]  pad_oe_o,
  output logic                  irq_o
);
  logic [NUM_LINES-1:0] cur, prev, status, mode, dir, dout, pol, edge_sel, both, mask, clr;
  det_cfg_t cfg;

  initial begin
    if (NUM_LINES < 1 || NUM_LINES > MAX_LINES) $error("NUM_LINES out of range");
  end

  gpio_pin_sync #(.WIDTH(NUM_LINES)) u_sync (
    .clk_i, .rst_ni, .pin_i(pad_in_i), .cur_o(cur), .prev_o(prev)
  );

  gpio_reg_file #(.NUM_LINES(NUM_LINES)) u_regs (
    .clk_i, .rst_ni, .req_valid_i, .req_write_i, .req_addr_i, .req_wdata_i,
    .rsp_valid_o, .rsp_rdata_o, .din_i(cur), .status_i(status),
    .mode_o(mode), .dir_o(dir), .dout_o(dout), .pol_o(pol), .edge_o(edge_sel),
    .both_o(both), .mask_o(mask), .clr_o(clr)
  );

  always_comb begin
    cfg          = '0;
    cfg.mode     = MAX_LINES'(mode);
    cfg.pol      = MAX_LINES'(pol);
    cfg.edge_sel = MAX_LINES'(edge_sel);
    cfg.both     = MAX_LINES'(both);
  end

  gpio_irq_detect #(.NUM_LINES(NUM_LINES)) u_detect (
    .clk_i, .rst_ni, .cur_i(cur), .prev_i(prev), .cfg_i(cfg), .clr_i(clr),
    .status_o(status)
  );

  assign req_ready_o = rst_ni;
  assign pad_out_o   = dout;
  assign pad_oe_o    = ~mode & dir;
  assign irq_o       = |(status & mask);

  AST_IRQ_OFF_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask == '0) |-> !irq_o); // R9
  AST_OE_NEEDS_IO_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_oe_o & mode) == '0); // R2
endmodule

// File: tb/gpio_irq_bank_bench.sv
module gpio_irq_bank_bench;
  import gpio_bank_pkg::*;
  localparam int N = 32;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic req_valid_i = 1'b0, req_write_i = 1'b0, req_ready_o, rsp_valid_o, irq_o;
  logic [REG_ADDR_W-1:0] req_addr_i = '0;
  logic [31:0] req_wdata_i = '0, rsp_rdata_o;
  logic [N-1:0] pad_in_i = '0, pad_out_o, pad_oe_o;
  int tests = 0, fails = 0;

  always #2 clk_i = ~clk_i;

  gpio_irq_bank #(.NUM_LINES(N)) u_gpio_irq_bank (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [REG_ADDR_W-1:0] a, logic [31:0] d);
    @(negedge clk_i);
    req_valid_i = 1; req_write_i = 1; req_addr_i = a; req_wdata_i = d;
    @(negedge clk_i);
    req_valid_i = 0; req_write_i = 0;
  endtask

  task automatic rd(logic [REG_ADDR_W-1:0] a, output logic [31:0] d);
    @(negedge clk_i);
    req_valid_i = 1; req_write_i = 0; req_addr_i = a;
    @(negedge clk_i);
    req_valid_i = 0;
    chk("R11 rsp_valid", {31'd0, rsp_valid_o}, 32'd1);
    d = rsp_rdata_o;
  endtask

  task automatic pins(logic [N-1:0] v);
    @(negedge clk_i);
    pad_in_i = v;
    repeat (3) @(negedge clk_i);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    // R1 reset state
    chk("R1 oe", pad_oe_o, 0);
    chk("R1 irq", {31'd0, irq_o}, 0);
    chk("R11 ready", {31'd0, req_ready_o}, 1);
    rd(OFF_MODE, d); chk("R1 mode", d, 0);
    rd(OFF_DIR, d);  chk("R1 dir", d, 0);
    rd(OFF_MASK, d); chk("R1 mask", d, 0);
    rd(OFF_STAT, d); chk("R1 status", d, 0);

    // R2 per-line output enable sweep
    for (int i = 0; i < N; i++) begin
      logic [31:0] b = 32'd1 << i;
      wr(OFF_DIR, b);
      wr(OFF_MODE, i[0] ? b : 0);
      chk("R2 oe", pad_oe_o, i[0] ? 0 : b);
      wr(OFF_DOUT, b ^ 32'h5A5A_0FF0);
      chk("R2 pad_out", pad_out_o, b ^ 32'h5A5A_0FF0);
      rd(OFF_DOUT, d); chk("R2 dout readback", d, b ^ 32'h5A5A_0FF0);
    end
    wr(OFF_MODE, 0); wr(OFF_DIR, 0);
    chk("R2 oe off", pad_oe_o, 0);

    // R3 / R12 input data and its latency
    @(negedge clk_i); pad_in_i = 32'hA5C3_0F96;
    rd(OFF_DIN, d); chk("R12 din not yet", d, 0);
    rd(OFF_DIN, d); chk("R3 din", d, 32'hA5C3_0F96);
    wr(OFF_POL, 32'hFFFF_FFFF);
    rd(OFF_DIN, d); chk("R3 din no inversion", d, 32'hA5C3_0F96);
    wr(OFF_POL, 0);
    // R10 I/O-mode lines never set status
    pins(32'h5A3C_F069);
    pins(0);
    rd(OFF_STAT, d); chk("R10 status quiet", d, 0);

    // R11 status write ignored, unmapped reads zero
    wr(OFF_STAT, 32'hFFFF_FFFF);
    rd(OFF_STAT, d); chk("R11 status write ignored", d, 0);
    wr(OFF_UNMASK, 32'h0000_00F0);
    rd(OFF_UNMASK, d); chk("R11 unmask reads zero", d, 0);
    rd(7'h30, d); chk("R11 unmapped", d, 0);
    // R8 mask write semantics
    wr(OFF_MASK, 32'hFFFF_FFFF);
    rd(OFF_MASK, d); chk("R8 mask keep on ones", d, 32'h0000_00F0);
    wr(OFF_MASK, 32'hFFFF_FFBF);
    rd(OFF_MASK, d); chk("R8 mask clear on zero", d, 32'h0000_00B0);
    wr(OFF_MASK, 0);

    // R12 status latency on line 0, rising edge
    wr(OFF_EDGE, 1); wr(OFF_MODE, 1); wr(OFF_UNMASK, 1);
    @(negedge clk_i); pad_in_i = 1;
    repeat (2) @(negedge clk_i);
    chk("R12 irq not yet", {31'd0, irq_o}, 0);
    @(negedge clk_i);
    chk("R12 irq due", {31'd0, irq_o}, 1);
    wr(OFF_MODE, 0); wr(OFF_MASK, 0);
    pins(0);

    // R4-R9 sweep over edge, polarity and both-edge settings
    for (int c = 0; c < 8; c++) begin
      int l = c * 4 + 1;
      bit ed = c[0], po = c[1], bo = c[2];
      logic [31:0] b = 32'd1 << l;
      bit e;
      wr(OFF_MODE, 0);
      wr(OFF_POL, po ? b : 0); wr(OFF_EDGE, ed ? b : 0); wr(OFF_BOTH, bo ? b : 0);
      wr(OFF_MODE, b); wr(OFF_UNMASK, b);
      repeat (3) @(negedge clk_i);
      wr(OFF_CLR, b);
      e = ed ? 1'b0 : po;
      rd(OFF_STAT, d); chk(ed ? "R7 cleared" : "R4 level idle", d, e ? b : 0);
      chk("R9 irq idle", {31'd0, irq_o}, {31'd0, e});
      pins(b);
      e = ed ? (bo | !po) : !po;
      rd(OFF_STAT, d); chk(ed ? (bo ? "R6 rise" : "R5 rise") : "R4 level high", d, e ? b : 0);
      chk("R9 irq rise", {31'd0, irq_o}, {31'd0, e});
      wr(OFF_CLR, ~b);
      rd(OFF_STAT, d); chk("R7 zero bits keep", d, e ? b : 0);
      wr(OFF_MASK, ~b);
      chk("R8 masked irq", {31'd0, irq_o}, 0);
      rd(OFF_STAT, d); chk("R9 status under mask", d, e ? b : 0);
      wr(OFF_UNMASK, b);
      wr(OFF_CLR, b);
      e = ed ? 1'b0 : !po;
      rd(OFF_STAT, d); chk(ed ? "R7 clear" : "R4 clear no effect", d, e ? b : 0);
      pins(0);
      e = ed ? (bo | po) : po;
      rd(OFF_STAT, d); chk(ed ? (bo ? "R6 fall" : "R5 fall") : "R4 level low", d, e ? b : 0);
      chk("R9 irq fall", {31'd0, irq_o}, {31'd0, e});
      wr(OFF_MASK, 0);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule